// File: doc/BRIEF.md
# Widening Floating-Point Add/Subtract Decoder

This block sits in the issue stage of a vector unit. It takes a 32-bit instruction word and finds the widening floating-point add and subtract forms. For each one it decides whether the instruction is legal under the current element width, register grouping, vector length and enable state. The element width and grouping arrive as small encodings. In a widening operation the result elements are twice the width of the narrow source elements. The destination register group is therefore twice the size of a narrow source group, and the legality rules check alignment, overlap and the mask register against that larger footprint.

Each strobed instruction gives one registered result on the cycle after the strobe. The result holds:
- whether the word was recognised;
- whether it is illegal;
- add or subtract;
- whether the first source is already wide;
- whether the second operand is a floating-point scalar;
- the base register and register count of each group;
- a zero-length no-op flag;
- the rounding mode that applies.

Downstream sequencers use these fields to walk elements and to reach the register file. Those jobs are outside this block.

Top module: `wfas_decoder`

## Requirements
- R1: `out_valid` rises exactly one cycle after a cycle with `in_valid` high and is low one cycle after a cycle with `in_valid` low. Out of reset all outputs are zero.
- R2: `dec_hit` is 1 only when all three of these hold: bits [6:0] are 1010111; bits [31:26] are 110000, 110010, 110100 or 110110; bits [14:12] are 001 or 101. Any other word gives `dec_hit`=0, `dec_illegal`=0 and all other outputs zero.
- R3: A legal result reports `op_sub`=1 for bits [31:26] = 110010 or 110110. It reports `src2_wide`=1 for 110100 or 110110. It reports `src1_scalar`=1 for bits [14:12]=101, and 001 is the vector-vector form.
- R4: A recognised word is illegal in any of these cases: `vec_en`=0, `sew_code`=0, `sew_code`>=3, or `lmul_code`>=3.
- R5: With N = 1<<`lmul_code`, the group sizes are as follows:
  - `vd_cnt` is 2N.
  - `vs2_cnt` is 2N in the wide-first-source forms and N otherwise.
  - `vs1_cnt` is N in the vector-vector forms.
  - In the scalar forms `vs1_cnt` is 0 and `vs1_base` is 0.
  - `vd_base` is bits [11:7], `vs2_base` is bits [24:20] and `vs1_base` is bits [19:15].
- R6: A recognised word is illegal when `vd` (bits [11:7]), `vs2` or a vector `vs1` is not a multiple of its own group size.
- R7: A recognised word is illegal when the range [vd, vd+2N) intersects a narrow source range [vs, vs+N). The narrow sources are vs2 in the single-width forms and vs1 in the vector-vector forms. No overlap check applies between vd and a wide vs2.
- R8: A recognised word with bit 25 = 0 (masked) and a destination group that contains register 0 is illegal.
- R9: A legal vector-vector result has `is_noop`=1 exactly when `vl`=0. Scalar forms never report `is_noop`.
- R10: A legal result carries `rnd_mode` equal to the `frm` input of the strobe cycle, regardless of the instruction's own rounding field.
- R11: An illegal result has `dec_hit`=1, `dec_illegal`=1 and every other output zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 32 | Instruction word |
| sew_code | input | 3 | Current element-width encoding |
| lmul_code | input | 3 | Current register-grouping encoding |
| vl | input | VL_W | Current vector length |
| vec_en | input | 1 | Vector unit enabled |
| frm | input | 3 | Dynamic rounding mode |
| out_valid | output | 1 | Result valid |
| dec_hit | output | 1 | Word is a widening FP add/subtract |
| dec_illegal | output | 1 | Recognised but illegal |
| op_sub | output | 1 | Subtract operation |
| src2_wide | output | 1 | First source (vs2) is already wide |
| src1_scalar | output | 1 | Second operand is an FP scalar |
| is_noop | output | 1 | Zero-length vector-vector operation |
| rnd_mode | output | 3 | Rounding mode to apply |
| vd_base | output | 5 | Destination group base |
| vd_cnt | output | 4 | Destination group size |
| vs2_base | output | 5 | vs2 group base |
| vs2_cnt | output | 4 | vs2 group size |
| vs1_base | output | 5 | vs1 group base |
| vs1_cnt | output | 4 | vs1 group size |

## Verification
The hardest cases involve overlap, because overlap is only judged once all alignment rules already pass. A partial intersection needs both groups aligned and still sharing registers. So does the wide-source case, where vd equals vs2 and the word must still be legal. Random register numbers almost never reach these cases. Directed vectors therefore build them at each grouping level, for example vd=8 with vs1=9, and vd equal to vs2 in the wide forms. A random sweep then adds more cases, with alignment forced on half of the register fields.

// File: rtl/wfas_pkg.sv
`timescale 1ns/1ps
package wfas_pkg;

    localparam int REG_W    = 5;
    localparam int CNT_W    = 4;
    localparam int SPAN_W   = REG_W + 1;

    localparam logic [6:0] OPC_VFP   = 7'b1010111;
    localparam logic [5:0] F6_ADD    = 6'b110000;
    localparam logic [5:0] F6_SUB    = 6'b110010;
    localparam logic [5:0] F6_ADD_W  = 6'b110100;
    localparam logic [5:0] F6_SUB_W  = 6'b110110;
    localparam logic [2:0] F3_VV     = 3'b001;
    localparam logic [2:0] F3_VS     = 3'b101;
    localparam logic [2:0] SEW_LIMIT  = 3'd3;
    localparam logic [2:0] LMUL_LIMIT = 3'd3;

    typedef struct packed {
        logic             hit;
        logic             sub;
        logic             wide;
        logic             scalar;
        logic             masked;
        logic [REG_W-1:0] vd;
        logic [REG_W-1:0] vs2;
        logic [REG_W-1:0] vs1;
    } wfas_fields_t;

    typedef struct packed {
        logic             hit;
        logic             illegal;
        logic             sub;
        logic             wide;
        logic             scalar;
        logic             noop;
        logic [2:0]       rnd;
        logic [REG_W-1:0] vd_base;
        logic [CNT_W-1:0] vd_cnt;
        logic [REG_W-1:0] vs2_base;
        logic [CNT_W-1:0] vs2_cnt;
        logic [REG_W-1:0] vs1_base;
        logic [CNT_W-1:0] vs1_cnt;
    } wfas_result_t;

    // register count of a group: 1<<lm, doubled for the wide element size
    function automatic logic [CNT_W-1:0] grp_size(input logic [1:0] lm, input logic dbl);
        logic [2:0] sh;
        sh = {1'b0, lm} + {2'b00, dbl};
        return CNT_W'(1) << sh;
    endfunction

    function automatic logic is_aligned(input logic [REG_W-1:0] idx, input logic [CNT_W-1:0] size);
        logic [SPAN_W-1:0] mask;
        mask = SPAN_W'(size) - SPAN_W'(1);
        return ({1'b0, idx} & mask) == '0;
    endfunction

    // half-open ranges [a, a+na) and [b, b+nb) share at least one register
    function automatic logic ranges_meet(input logic [REG_W-1:0] a, input logic [CNT_W-1:0] na,
                                         input logic [REG_W-1:0] b, input logic [CNT_W-1:0] nb);
        logic [SPAN_W-1:0] a_end;
        logic [SPAN_W-1:0] b_end;
        a_end = {1'b0, a} + SPAN_W'(na);
        b_end = {1'b0, b} + SPAN_W'(nb);
        return (na != '0) && (nb != '0) && ({1'b0, a} < b_end) && ({1'b0, b} < a_end);
    endfunction

endpackage

// File: rtl/wfas_field_decode.sv
`timescale 1ns/1ps
module wfas_field_decode
    import wfas_pkg::*;
(
    input  logic [31:0]  instr,
    output wfas_fields_t fields
);

    logic [6:0] opc;
    logic [5:0] f6;
    logic [2:0] f3;
    logic       f6_ok;
    logic       f3_ok;

    assign opc = instr[6:0];
    assign f6  = instr[31:26];
    assign f3  = instr[14:12];

    always_comb begin
        unique case (f6)
            F6_ADD, F6_SUB, F6_ADD_W, F6_SUB_W: f6_ok = 1'b1;
            default:                            f6_ok = 1'b0;
        endcase
        f3_ok = (f3 == F3_VV) || (f3 == F3_VS);
    end

    always_comb begin
        fields.hit    = (opc == OPC_VFP) && f6_ok && f3_ok;
        fields.sub    = f6[1];
        fields.wide   = f6[2];
        fields.scalar = f3[2];
        fields.masked = ~instr[25];
        fields.vd     = instr[11:7];
        fields.vs2    = instr[24:20];
        fields.vs1    = instr[19:15];
    end

endmodule

// File: rtl/wfas_group_check.sv
`timescale 1ns/1ps
module wfas_group_check
    import wfas_pkg::*;
#(
    parameter int VL_W = 16
) (
    input  wfas_fields_t     fields,
    input  logic [2:0]       sew_code,
    input  logic [2:0]       lmul_code,
    input  logic [VL_W-1:0]  vl,
    input  logic             vec_en,
    input  logic [2:0]       frm,
    output wfas_result_t     res
);

    logic [1:0]       lm;
    logic [CNT_W-1:0] n_narrow;
    logic [CNT_W-1:0] n_wide;
    logic [CNT_W-1:0] vd_n;
    logic [CNT_W-1:0] vs2_n;
    logic [CNT_W-1:0] vs1_n;
    logic             env_bad;
    logic             align_bad;
    logic             ovl_bad;
    logic             v0_bad;
    logic             legal;

    assign lm = lmul_code[1:0];

    always_comb begin
        env_bad  = !vec_en || (sew_code == 3'd0) || (sew_code >= SEW_LIMIT)
                   || (lmul_code >= LMUL_LIMIT);
        n_narrow = grp_size(lm, 1'b0);
        n_wide   = grp_size(lm, 1'b1);
        vd_n     = n_wide;
        vs2_n    = fields.wide   ? n_wide : n_narrow;
        vs1_n    = fields.scalar ? '0     : n_narrow;

        align_bad = !is_aligned(fields.vd, vd_n)
                 || !is_aligned(fields.vs2, vs2_n)
                 || (!fields.scalar && !is_aligned(fields.vs1, n_narrow));

        // a wide vs2 shares the destination element width, so it may overlap vd
        ovl_bad = (!fields.wide && ranges_meet(fields.vd, vd_n, fields.vs2, vs2_n))
               || ranges_meet(fields.vd, vd_n, fields.vs1, vs1_n);

        v0_bad = fields.masked && ranges_meet(fields.vd, vd_n, '0, CNT_W'(1));

        legal = fields.hit && !(env_bad || align_bad || ovl_bad || v0_bad);
    end

    always_comb begin
        res         = '0;
        res.hit     = fields.hit;
        res.illegal = fields.hit && !legal;
        if (legal) begin
            res.sub      = fields.sub;
            res.wide     = fields.wide;
            res.scalar   = fields.scalar;
            res.noop     = !fields.scalar && (vl == '0);
            res.rnd      = frm;
            res.vd_base  = fields.vd;
            res.vd_cnt   = vd_n;
            res.vs2_base = fields.vs2;
            res.vs2_cnt  = vs2_n;
            res.vs1_base = fields.scalar ? '0 : fields.vs1;
            res.vs1_cnt  = vs1_n;
        end
    end

endmodule

// File: rtl/wfas_decoder.sv
`timescale 1ns/1ps
module wfas_decoder
    import wfas_pkg::*;
#(
    parameter int VL_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [31:0]      instr,
    input  logic [2:0]       sew_code,
    input  logic [2:0]       lmul_code,
    input  logic [VL_W-1:0]  vl,
    input  logic             vec_en,
    input  logic [2:0]       frm,
    output logic             out_valid,
    output logic             dec_hit,
    output logic             dec_illegal,
    output logic             op_sub,
    output logic             src2_wide,
    output logic             src1_scalar,
    output logic             is_noop,
    output logic [2:0]       rnd_mode,
    output logic [4:0]       vd_base,
    output logic [3:0]       vd_cnt,
    output logic [4:0]       vs2_base,
    output logic [3:0]       vs2_cnt,
    output logic [4:0]       vs1_base,
    output logic [3:0]       vs1_cnt
);

    wfas_fields_t fields;
    wfas_result_t res_nxt;
    wfas_result_t res_q;
    logic         valid_q;

    wfas_field_decode u_fields (
        .instr  (instr),
        .fields (fields)
    );

    wfas_group_check #(.VL_W(VL_W)) u_groups (
        .fields    (fields),
        .sew_code  (sew_code),
        .lmul_code (lmul_code),
        .vl        (vl),
        .vec_en    (vec_en),
        .frm       (frm),
        .res       (res_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                res_q <= res_nxt;
            end
        end
    end

    assign out_valid   = valid_q;
    assign dec_hit     = res_q.hit;
    assign dec_illegal = res_q.illegal;
    assign op_sub      = res_q.sub;
    assign src2_wide   = res_q.wide;
    assign src1_scalar = res_q.scalar;
    assign is_noop     = res_q.noop;
    assign rnd_mode    = res_q.rnd;
    assign vd_base     = res_q.vd_base;
    assign vd_cnt      = res_q.vd_cnt;
    assign vs2_base    = res_q.vs2_base;
    assign vs2_cnt     = res_q.vs2_cnt;
    assign vs1_base    = res_q.vs1_base;
    assign vs1_cnt     = res_q.vs1_cnt;

endmodule

// File: rtl/wfas_decoder_chk.sv
`timescale 1ns/1ps
module wfas_decoder_chk #(
    parameter int VL_W = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic [2:0]      sew_code,
    input logic [2:0]      lmul_code,
    input logic [VL_W-1:0] vl,
    input logic            vec_en,
    input logic [2:0]      frm,
    input logic            out_valid,
    input logic            dec_hit,
    input logic            dec_illegal,
    input logic            op_sub,
    input logic            src2_wide,
    input logic            src1_scalar,
    input logic            is_noop,
    input logic [2:0]      rnd_mode,
    input logic [4:0]      vd_base,
    input logic [3:0]      vd_cnt,
    input logic [4:0]      vs2_base,
    input logic [3:0]      vs2_cnt,
    input logic [4:0]      vs1_base,
    input logic [3:0]      vs1_cnt
);

    logic legal_out;
    assign legal_out = out_valid && dec_hit && !dec_illegal;

    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_drops_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_wrong_opcode_R2: assert property (@(posedge clk) disable iff (rst)
        in_valid && (instr[6:0] != 7'b1010111) |=> !dec_hit && !dec_illegal);
    assert_miss_zero_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid && !dec_hit |-> !dec_illegal && !op_sub && vd_cnt == 4'd0 && vs2_cnt == 4'd0);

    assert_vs1_form_R3: assert property (@(posedge clk) disable iff (rst)
        legal_out |-> src1_scalar == (vs1_cnt == 4'd0));

    assert_disabled_R4: assert property (@(posedge clk) disable iff (rst)
        in_valid && (!vec_en || sew_code == 3'd0 || sew_code >= 3'd3 || lmul_code >= 3'd3)
        |=> !(dec_hit && !dec_illegal));

    assert_group_ratio_R5: assert property (@(posedge clk) disable iff (rst)
        legal_out |-> $countones(vd_cnt) == 1
                      && (src2_wide ? (vs2_cnt == vd_cnt) : ({vs2_cnt, 1'b0} == {1'b0, vd_cnt})));

    assert_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        legal_out |-> ((vd_base & 5'(vd_cnt - 4'd1)) == 5'd0)
                      && ((vs2_base & 5'(vs2_cnt - 4'd1)) == 5'd0));

    assert_vs1_apart_R7: assert property (@(posedge clk) disable iff (rst)
        legal_out && vs1_cnt != 4'd0 |->
            ({1'b0, vs1_base} + 6'(vs1_cnt) <= {1'b0, vd_base})
         || ({1'b0, vd_base} + 6'(vd_cnt) <= {1'b0, vs1_base}));
    assert_vs2_apart_R7: assert property (@(posedge clk) disable iff (rst)
        legal_out && !src2_wide |->
            ({1'b0, vs2_base} + 6'(vs2_cnt) <= {1'b0, vd_base})
         || ({1'b0, vd_base} + 6'(vd_cnt) <= {1'b0, vs2_base}));

    assert_mask_v0_R8: assert property (@(posedge clk) disable iff (rst)
        in_valid && !instr[25] && instr[11:7] == 5'd0 |=> !(dec_hit && !dec_illegal));

    assert_noop_scalar_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && src1_scalar |-> !is_noop);
    assert_noop_zero_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid && vl == '0 && instr[14:12] == 3'b001 |=> !(dec_hit && !dec_illegal) || is_noop);

    assert_round_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> !(dec_hit && !dec_illegal) || rnd_mode == $past(frm));

    assert_illegal_zero_R11: assert property (@(posedge clk) disable iff (rst)
        out_valid && dec_illegal |-> dec_hit && !op_sub && !src2_wide && !src1_scalar && !is_noop
            && rnd_mode == 3'd0 && vd_base == 5'd0 && vd_cnt == 4'd0 && vs2_base == 5'd0
            && vs2_cnt == 4'd0 && vs1_base == 5'd0 && vs1_cnt == 4'd0);

endmodule

bind wfas_decoder wfas_decoder_chk #(.VL_W(VL_W)) u_chk (.*);

// File: tb/wfas_decoder_test.sv
`timescale 1ns/1ps
module wfas_decoder_test;

    typedef struct packed {
        logic       hit;
        logic       illegal;
        logic       sub;
        logic       wide;
        logic       scalar;
        logic       noop;
        logic [2:0] rnd;
        logic [4:0] vd_base;
        logic [3:0] vd_cnt;
        logic [4:0] vs2_base;
        logic [3:0] vs2_cnt;
        logic [4:0] vs1_base;
        logic [3:0] vs1_cnt;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [2:0]  sew_code = '0;
    logic [2:0]  lmul_code = '0;
    logic [15:0] vl = '0;
    logic        vec_en = 1'b0;
    logic [2:0]  frm = '0;
    logic        out_valid, dec_hit, dec_illegal, op_sub, src2_wide, src1_scalar, is_noop;
    logic [2:0]  rnd_mode;
    logic [4:0]  vd_base, vs2_base, vs1_base;
    logic [3:0]  vd_cnt, vs2_cnt, vs1_cnt;

    int checks = 0;
    int fails  = 0;
    exp_t  exp_q[$];
    string tag_q[$];
    logic  pend = 1'b0;

    always #10 clk = ~clk;

    wfas_decoder #(.VL_W(16)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .sew_code(sew_code), .lmul_code(lmul_code), .vl(vl), .vec_en(vec_en), .frm(frm),
        .out_valid(out_valid), .dec_hit(dec_hit), .dec_illegal(dec_illegal),
        .op_sub(op_sub), .src2_wide(src2_wide), .src1_scalar(src1_scalar),
        .is_noop(is_noop), .rnd_mode(rnd_mode),
        .vd_base(vd_base), .vd_cnt(vd_cnt), .vs2_base(vs2_base), .vs2_cnt(vs2_cnt),
        .vs1_base(vs1_base), .vs1_cnt(vs1_cnt)
    );

    function automatic logic [31:0] mk(logic [5:0] f6, logic vm, logic [4:0] s2,
                                       logic [4:0] s1, logic [2:0] f3, logic [4:0] d);
        return {f6, vm, s2, s1, f3, d, 7'b1010111};
    endfunction

    function automatic exp_t model(logic [31:0] ins, logic [2:0] sew, logic [2:0] lm,
                                   logic [15:0] vlv, logic en, logic [2:0] fr);
        exp_t e;
        bit   bad;
        bit   isw;
        bit   isv;
        bit   ind;
        int   n, w, d, s2, s1, s2n, s1n;
        e = '0;
        if (!((ins[6:0] == 7'b1010111)
              && (ins[31:26] inside {6'b110000, 6'b110010, 6'b110100, 6'b110110})
              && (ins[14:12] == 3'b001 || ins[14:12] == 3'b101)))
            return e;
        e.hit = 1'b1;
        isw = ins[28];
        isv = (ins[14] == 1'b0);
        d   = int'(ins[11:7]);
        s2  = int'(ins[24:20]);
        s1  = int'(ins[19:15]);
        bad = !en || sew == 3'd0 || sew > 3'd2 || lm > 3'd2;
        n = 1; w = 2; s2n = 1; s1n = 0;
        if (!bad) begin
            n   = 1 << lm;
            w   = 2 * n;
            s2n = isw ? w : n;
            s1n = isv ? n : 0;
            if (d % w != 0) bad = 1;
            if (s2 % s2n != 0) bad = 1;
            if (isv && (s1 % n != 0)) bad = 1;
            for (int r = 0; r < 32; r++) begin
                ind = (r >= d) && (r < d + w);
                if (ind && !isw && r >= s2 && r < s2 + s2n) bad = 1;
                if (ind && isv && r >= s1 && r < s1 + n) bad = 1;
            end
            if (!ins[25] && d == 0) bad = 1;
        end
        if (bad) begin
            e.illegal = 1'b1;
            return e;
        end
        e.sub      = ins[27];
        e.wide     = isw;
        e.scalar   = !isv;
        e.noop     = isv && (vlv == 16'd0);
        e.rnd      = fr;
        e.vd_base  = ins[11:7];
        e.vd_cnt   = 4'(w);
        e.vs2_base = ins[24:20];
        e.vs2_cnt  = 4'(s2n);
        e.vs1_base = isv ? ins[19:15] : 5'd0;
        e.vs1_cnt  = 4'(s1n);
        return e;
    endfunction

    task automatic drive(string tag, logic [31:0] ins, logic [2:0] sew, logic [2:0] lm,
                         logic [15:0] vlv, logic en, logic [2:0] fr);
        @(negedge clk);
        instr     = ins;
        sew_code  = sew;
        lmul_code = lm;
        vl        = vlv;
        vec_en    = en;
        frm       = fr;
        in_valid  = 1'b1;
        exp_q.push_back(model(ins, sew, lm, vlv, en, fr));
        tag_q.push_back(tag);
    endtask

    task automatic idle(int cycles);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            instr    = $urandom;
        end
    endtask

    always @(posedge clk) pend <= in_valid && !rst;

    always @(negedge clk) begin
        if (!rst) begin
            exp_t  e;
            exp_t  a;
            string t;
            a = {dec_hit, dec_illegal, op_sub, src2_wide, src1_scalar, is_noop, rnd_mode,
                 vd_base, vd_cnt, vs2_base, vs2_cnt, vs1_base, vs1_cnt};
            if (out_valid !== pend) begin
                checks++;
                fails++;
                $display("FAIL R1 out_valid actual=%b expected=%b", out_valid, pend);
            end
            if (pend) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R1 result without stimulus actual=%h expected=none", a);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (a !== e) begin
                        fails++;
                        $display("FAIL %s actual=%h expected=%h", t, a, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (10000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({out_valid, dec_hit, dec_illegal, vd_cnt, vs2_cnt, vs1_cnt, rnd_mode} !== '0) begin
            fails++;
            $display("FAIL R1 reset state actual=%b expected=0",
                     {out_valid, dec_hit, dec_illegal, vd_cnt, vs2_cnt, vs1_cnt, rnd_mode});
        end

        // R3 and R5: the four operations, both operand forms
        drive("R3 add vv",        mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd8, 1, 3'd0);
        drive("R3 sub vs",        mk(6'b110010, 1, 5'd8, 5'd3, 3'b101, 5'd4), 3'd2, 3'd1, 16'd8, 1, 3'd1);
        drive("R3 add wide vv",   mk(6'b110100, 1, 5'd8, 5'd2, 3'b001, 5'd4), 3'd1, 3'd1, 16'd4, 1, 3'd2);
        drive("R5 lmul2 vv",      mk(6'b110000, 1, 5'd4, 5'd16, 3'b001, 5'd8), 3'd1, 3'd2, 16'd9, 1, 3'd4);
        drive("R5 sub wide vs",   mk(6'b110110, 1, 5'd16, 5'd7, 3'b101, 5'd24), 3'd2, 3'd2, 16'd9, 1, 3'd3);
        // R7: wide vs2 may equal vd; narrow overlap is illegal
        drive("R7 wide vs2==vd",  mk(6'b110110, 1, 5'd2, 5'd6, 3'b001, 5'd2), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R7 vs2 overlap",   mk(6'b110000, 1, 5'd5, 5'd7, 3'b001, 5'd4), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R7 vs1 overlap",   mk(6'b110010, 1, 5'd1, 5'd9, 3'b001, 5'd8), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R7 vs1 lmul1 ovl", mk(6'b110100, 1, 5'd16, 5'd10, 3'b001, 5'd8), 3'd1, 3'd1, 16'd1, 1, 3'd0);
        drive("R7 vs1 adjacent",  mk(6'b110000, 1, 5'd1, 5'd10, 3'b001, 5'd8), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        // R6: alignment
        drive("R6 vd odd",        mk(6'b110000, 1, 5'd4, 5'd6, 3'b001, 5'd3), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R6 wide vs2 odd",  mk(6'b110100, 1, 5'd3, 5'd6, 3'b001, 5'd8), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R6 vs1 odd lmul1", mk(6'b110000, 1, 5'd4, 5'd3, 3'b001, 5'd8), 3'd1, 3'd1, 16'd1, 1, 3'd0);
        drive("R6 scalar rs1 odd",mk(6'b110000, 1, 5'd4, 5'd3, 3'b101, 5'd8), 3'd1, 3'd1, 16'd1, 1, 3'd5);
        // R4: environment
        drive("R4 disabled",      mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd1, 0, 3'd0);
        drive("R4 sew0",          mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd0, 3'd0, 16'd1, 1, 3'd0);
        drive("R4 sew3",          mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd3, 3'd0, 16'd1, 1, 3'd0);
        drive("R4 lmul3",         mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd16), 3'd1, 3'd3, 16'd1, 1, 3'd0);
        drive("R4 lmul7",         mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd16), 3'd2, 3'd7, 16'd1, 1, 3'd0);
        // R8: mask register in destination
        drive("R8 masked vd0",    mk(6'b110000, 0, 5'd4, 5'd5, 3'b001, 5'd0), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R8 masked vd2",    mk(6'b110000, 0, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd1, 1, 3'd6);
        drive("R8 unmasked vd0",  mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd0), 3'd1, 3'd0, 16'd1, 1, 3'd7);
        // R9: zero length
        drive("R9 vv vl0",        mk(6'b110010, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd0, 1, 3'd0);
        drive("R9 vs vl0",        mk(6'b110010, 1, 5'd4, 5'd5, 3'b101, 5'd2), 3'd1, 3'd0, 16'd0, 1, 3'd0);
        // R2: not recognised
        drive("R2 opcode",        {25'h1000000, 7'b1010011}, 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R2 funct3",        mk(6'b110000, 1, 5'd4, 5'd5, 3'b000, 5'd2), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        drive("R2 funct6",        mk(6'b110001, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd1, 1, 3'd0);
        // R10: dynamic rounding mode reported
        drive("R10 frm",          mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd2, 3'd0, 16'd3, 1, 3'd5);
        // R1: gap in strobes
        idle(3);
        drive("R1 after gap",     mk(6'b110100, 1, 5'd2, 5'd9, 3'b101, 5'd2), 3'd1, 3'd0, 16'd3, 1, 3'd2);
        idle(1);
        drive("R11 back to back a", mk(6'b110000, 1, 5'd3, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd3, 1, 3'd2);
        drive("R11 back to back b", mk(6'b110000, 1, 5'd4, 5'd5, 3'b001, 5'd2), 3'd1, 3'd0, 16'd3, 1, 3'd2);

        for (int k = 0; k < 400; k++) begin
            logic [5:0] f6;
            logic [2:0] f3;
            logic [2:0] lm;
            logic [4:0] d, s2, s1;
            logic [31:0] ins;
            f6 = ($urandom % 8 == 0) ? 6'($urandom) : {3'b110, 2'($urandom), 1'b0};
            f3 = ($urandom % 8 == 0) ? 3'($urandom) : (($urandom % 2 == 0) ? 3'b001 : 3'b101);
            lm = ($urandom % 6 == 0) ? 3'($urandom) : 3'($urandom % 3);
            d  = 5'($urandom);
            s2 = 5'($urandom);
            s1 = 5'($urandom);
            if ($urandom % 2 == 0) begin
                d  = d  & ~(5'd1 << lm[1:0]) & ~5'((1 << lm[1:0]) - 1);
                s2 = s2 & ~5'((2 << lm[1:0]) - 1);
                s1 = s1 & ~5'((1 << lm[1:0]) - 1);
            end
            ins = mk(f6, 1'($urandom), s2, s1, f3, d);
            if ($urandom % 16 == 0) ins[6:0] = 7'($urandom);
            drive("R5 R6 R7 random", ins, 3'($urandom % 4), lm, 16'($urandom % 3),
                  ($urandom % 8 != 0), 3'($urandom));
            if ($urandom % 5 == 0) idle(1);
        end

        idle(3);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule